// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits on the receive path behind the MAC's framing logic. It takes each incoming Ethernet frame as a byte stream marked with start-of-frame and end-of-frame flags and a CRC-error flag that is valid on the last byte. It holds the frame in an on-chip ring buffer while the frame arrives. When the last byte is in, it decides whether to keep or discard the frame. Kept frames are played out on an output byte stream, optionally without their 4-byte FCS, and a length strobe comes with the last byte. Discarded frames leave nothing behind.

The decision uses a 48-bit station address and two independent discard enables. One drops frames whose destination address differs from the station address. The other drops group-addressed (multicast) frames. Clearing both enables gives promiscuous reception. A programmable maximum length, a fixed 60-byte minimum and the CRC-error flag also reject frames. Four saturating counters record drops by cause.

Top module: `rx_da_filter`

## Requirements
- R1: After reset, out_valid, out_last, out_len, frame_accept and frame_drop are 0, and all four drop counters read 0.
- R2: The destination address is the first six bytes of the frame, received in order octet 0 to octet 5. Octet 0 to octet 3 are compared against cfg_addr_lo bits [7:0], [15:8], [23:16] and [31:24], and octet 4 and octet 5 against cfg_addr_hi bits [7:0] and [15:8]. With cfg_drop_addr = 1, a frame whose address differs in any octet is dropped and counted in cnt_addr. A matching frame is delivered.
- R3: A frame is multicast when bit 0 of its first byte is 1. With cfg_drop_mcast = 1 such a frame is dropped and counted in cnt_mcast. If it also fails the address compare, it counts as multicast only.
- R4: With both discard enables at 0, good frames are accepted whatever their destination address: station, other unicast, broadcast or multicast.
- R5: The broadcast address (all octets 0xFF) is multicast. With only cfg_drop_addr set, it is accepted only when the station address is all ones.
- R6: A frame whose total length (FCS included) exceeds cfg_max_len is dropped and counted in cnt_long. A frame exactly cfg_max_len long is accepted.
- R7: A frame shorter than 60 bytes is dropped without touching any counter. A 60-byte frame is accepted.
- R8: A frame with in_crc_err high on its end beat is dropped and counted in cnt_crc. This cause takes priority over every other cause, including a 1-byte frame.
- R9: With cfg_strip_fcs = 1, an accepted frame is delivered without its last 4 bytes and out_len is the total length minus 4. With cfg_strip_fcs = 0, every byte is delivered.
- R10: An accepted frame's bytes appear on out_data in arrival order, one per out_valid cycle. out_last marks the final byte and out_len then equals the number of bytes delivered. A dropped frame produces no out_valid and no out_last.
- R11: Exactly one of frame_accept and frame_drop pulses for one cycle, on the cycle after the end beat is sampled. The drop counter changes on that same cycle.
- R12: Each drop counter saturates at 2^CNT_W-1 and never wraps.
- R13: A start beat arriving while a frame is still open abandons the open frame. It produces no decision pulse and no output, and the new frame is handled normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| in_crc_err | input | 1 | CRC error, valid with in_eof |
| cfg_addr_lo | input | 32 | Station address octets 0..3 |
| cfg_addr_hi | input | 16 | Station address octets 4..5 |
| cfg_drop_addr | input | 1 | Drop frames whose address differs from the station |
| cfg_drop_mcast | input | 1 | Drop multicast frames |
| cfg_strip_fcs | input | 1 | Remove the 4-byte FCS from delivered frames |
| cfg_max_len | input | BUF_AW+1 | Longest accepted frame, FCS included |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Last byte of a delivered frame |
| out_len | output | BUF_AW+1 | Delivered length, valid with out_last |
| frame_accept | output | 1 | Frame accepted pulse |
| frame_drop | output | 1 | Frame dropped pulse |
| cnt_addr | output | CNT_W | Drops for address mismatch |
| cnt_mcast | output | CNT_W | Drops for multicast |
| cnt_long | output | CNT_W | Drops for oversize |
| cnt_crc | output | CNT_W | Drops for CRC error |

## Verification
The bench sweeps every combination of the two discard enables against station, foreign unicast, broadcast and multicast addresses, with FCS stripping on and off. It also steps the frame length across the 60-byte floor and across the programmed maximum. A design with a wrong octet order or a wrong multicast bit accepts or drops the wrong cells of that grid. An off-by-one length compare shows up at exactly 59/60 bytes or at the maximum. A wrong cause priority bumps the wrong counter when the CRC flag meets a runt, an oversize or a foreign address. A rewind that fails after a drop, or after an abandoned frame, shows up as stale bytes or a wrong length on the next delivered frame. A wrapping counter shows up once twenty CRC drops pass a 4-bit counter.

// File: rtl/rx_da_filter_pkg.sv
package rx_da_filter_pkg;

  typedef enum logic [2:0] {
    DROP_NONE  = 3'd0,
    DROP_CRC   = 3'd1,
    DROP_RUNT  = 3'd2,
    DROP_LONG  = 3'd3,
    DROP_MCAST = 3'd4,
    DROP_ADDR  = 3'd5,
    DROP_ROOM  = 3'd6
  } drop_cause_e;

  localparam int NUM_DROP_CNT = 4;
  localparam int ADDR_BYTES   = 6;
  localparam int FCS_BYTES    = 4;

endpackage

// File: rtl/rx_da_classify.sv
module rx_da_classify
  import rx_da_filter_pkg::*;
#(
  parameter int LEN_W   = 12,
  parameter int MIN_LEN = 60
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             in_crc_err,
  input  logic [47:0]      station,
  input  logic             drop_addr_en,
  input  logic             drop_mcast_en,
  input  logic             strip_fcs,
  input  logic [LEN_W-1:0] max_len,
  input  logic             ring_room,
  input  logic             list_full,
  output logic             wr_en,
  output logic             wr_restart,
  output logic             end_fire,
  output logic             end_accept,
  output drop_cause_e      end_cause,
  output logic [LEN_W-1:0] keep_len,
  output logic             dec_accept_q,
  output logic             dec_drop_q
);

  localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

  logic             open_q;
  logic [LEN_W-1:0] len_q;
  logic             ovf_q;
  logic [7:0]       da_q [ADDR_BYTES];

  logic             beat;
  logic [LEN_W-1:0] idx;
  logic [LEN_W-1:0] new_len;
  logic             store_ok;
  logic             ovf_now;
  logic             addr_hit;
  logic             is_group;

  assign beat       = in_valid && (in_sof || open_q);
  assign idx        = in_sof ? '0 : len_q;
  assign new_len    = (idx == LEN_MAX) ? idx : idx + 1'b1;
  assign wr_restart = in_valid && in_sof;
  assign store_ok   = beat && (idx < max_len);
  assign wr_en      = store_ok && ring_room;
  assign ovf_now    = (!in_sof && ovf_q) || (store_ok && !ring_room);
  assign end_fire   = beat && in_eof;
  assign is_group   = da_q[0][0];

  always_comb begin
    addr_hit = 1'b1;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (da_q[i] != station[8*i +: 8]) addr_hit = 1'b0;
    end
  end

  always_comb begin
    if (in_crc_err)                           end_cause = DROP_CRC;
    else if (new_len < LEN_W'(MIN_LEN))       end_cause = DROP_RUNT;
    else if (new_len > max_len || idx == LEN_MAX) end_cause = DROP_LONG;
    else if (drop_mcast_en && is_group)       end_cause = DROP_MCAST;
    else if (drop_addr_en && !addr_hit)       end_cause = DROP_ADDR;
    else if (ovf_now || list_full)            end_cause = DROP_ROOM;
    else                                      end_cause = DROP_NONE;
  end

  assign end_accept = (end_cause == DROP_NONE);
  assign keep_len   = strip_fcs ? new_len - LEN_W'(FCS_BYTES) : new_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q       <= 1'b0;
      len_q        <= '0;
      ovf_q        <= 1'b0;
      dec_accept_q <= 1'b0;
      dec_drop_q   <= 1'b0;
      for (int i = 0; i < ADDR_BYTES; i++) da_q[i] <= '0;
    end else begin
      dec_accept_q <= end_fire && end_accept;
      dec_drop_q   <= end_fire && !end_accept;
      if (beat) begin
        open_q <= !in_eof;
        len_q  <= new_len;
        ovf_q  <= ovf_now;
        for (int i = 0; i < ADDR_BYTES; i++) begin
          if (idx == LEN_W'(i)) da_q[i] <= in_data;
        end
      end
    end
  end

  // R11
  decision_after_end_chk: assert property (@(posedge clk) disable iff (rst)
    (dec_accept_q || dec_drop_q) |-> $past(in_valid && in_eof));

  // R11
  single_decision_chk: assert property (@(posedge clk) disable iff (rst)
    !(dec_accept_q && dec_drop_q));

endmodule

// File: rtl/rx_da_ring.sv
module rx_da_ring #(
  parameter int AW = 11
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic        wr_restart,
  input  logic [7:0]  wr_data,
  input  logic        fin_keep,
  input  logic        fin_drop,
  input  logic [AW:0] fin_len,
  input  logic        rd_en,
  output logic [7:0]  rd_data,
  output logic        room
);

  localparam int          DEPTH = 1 << AW;
  localparam logic [AW:0] FULL  = AW'(0) | (AW+1)'(DEPTH);

  logic [7:0] mem [DEPTH];
  logic [AW:0] wp, cm, rp;
  logic [AW:0] wp_eff;

  assign wp_eff = wr_restart ? cm : wp;
  assign room   = (wp_eff - rp) != FULL;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wp_eff[AW-1:0]] <= wr_data;
    if (rd_en) rd_data <= mem[rp[AW-1:0]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      cm <= '0;
      rp <= '0;
    end else begin
      if (fin_keep) begin
        cm <= cm + fin_len;
        wp <= cm + fin_len;
      end else if (fin_drop) begin
        wp <= cm;
      end else if (wr_en) begin
        wp <= wp_eff + 1'b1;
      end else if (wr_restart) begin
        wp <= cm;
      end
      if (rd_en) rp <= rp + 1'b1;
    end
  end

  // R10
  read_committed_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (rp != cm));

  // R10
  ring_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (wp - rp) <= FULL);

endmodule

// File: rtl/rx_da_lenq.sv
module rx_da_lenq #(
  parameter int W  = 12,
  parameter int AW = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);

  localparam int DEPTH = 1 << AW;

  logic [W-1:0]  slot [DEPTH];
  logic [AW-1:0] wi, ri;
  logic [AW:0]   fill;

  assign empty = (fill == '0);
  assign full  = (fill == (AW+1)'(DEPTH));
  assign dout  = slot[ri];

  always_ff @(posedge clk) begin
    if (push) slot[wi] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wi   <= '0;
      ri   <= '0;
      fill <= '0;
    end else begin
      if (push) wi <= wi + 1'b1;
      if (pop)  ri <= ri + 1'b1;
      fill <= fill + (AW+1)'(push) - (AW+1)'(pop);
    end
  end

  // R10
  lenq_no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    !(push && full));

  // R10
  lenq_no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    !(pop && empty));

endmodule

// File: rtl/rx_da_satcnt.sv
module rx_da_satcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)                    q <= '0;
    else if (inc && q != '1)    q <= q + 1'b1;
  end

  // R12
  sat_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    q >= $past(q));

  // R12
  sat_step_chk: assert property (@(posedge clk) disable iff (rst)
    (q - $past(q)) <= W'(1));

endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
  import rx_da_filter_pkg::*;
#(
  parameter int BUF_AW  = 11,
  parameter int CNT_W   = 16,
  parameter int LIST_AW = 2,
  parameter int MIN_LEN = 60,
  localparam int LEN_W  = BUF_AW + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic             in_crc_err,
  input  logic [31:0]      cfg_addr_lo,
  input  logic [15:0]      cfg_addr_hi,
  input  logic             cfg_drop_addr,
  input  logic             cfg_drop_mcast,
  input  logic             cfg_strip_fcs,
  input  logic [LEN_W-1:0] cfg_max_len,
  output logic             out_valid,
  output logic [7:0]       out_data,
  output logic             out_last,
  output logic [LEN_W-1:0] out_len,
  output logic             frame_accept,
  output logic             frame_drop,
  output logic [CNT_W-1:0] cnt_addr,
  output logic [CNT_W-1:0] cnt_mcast,
  output logic [CNT_W-1:0] cnt_long,
  output logic [CNT_W-1:0] cnt_crc
);

  logic             wr_en, wr_restart, end_fire, end_accept;
  drop_cause_e      end_cause;
  logic [LEN_W-1:0] keep_len;
  logic             ring_room, list_full, list_empty;
  logic [LEN_W-1:0] list_head;
  logic             pop, rd_en;
  logic             busy;
  logic [LEN_W-1:0] rem, cur_len;

  rx_da_classify #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_classify (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .in_crc_err(in_crc_err),
    .station({cfg_addr_hi, cfg_addr_lo}),
    .drop_addr_en(cfg_drop_addr), .drop_mcast_en(cfg_drop_mcast),
    .strip_fcs(cfg_strip_fcs), .max_len(cfg_max_len),
    .ring_room(ring_room), .list_full(list_full),
    .wr_en(wr_en), .wr_restart(wr_restart),
    .end_fire(end_fire), .end_accept(end_accept), .end_cause(end_cause),
    .keep_len(keep_len),
    .dec_accept_q(frame_accept), .dec_drop_q(frame_drop)
  );

  rx_da_ring #(.AW(BUF_AW)) u_ring (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_restart(wr_restart), .wr_data(in_data),
    .fin_keep(end_fire && end_accept), .fin_drop(end_fire && !end_accept),
    .fin_len(keep_len),
    .rd_en(rd_en), .rd_data(out_data), .room(ring_room)
  );

  rx_da_lenq #(.W(LEN_W), .AW(LIST_AW)) u_lenq (
    .clk(clk), .rst(rst),
    .push(end_fire && end_accept), .din(keep_len),
    .pop(pop), .dout(list_head), .empty(list_empty), .full(list_full)
  );

  logic [NUM_DROP_CNT-1:0] cnt_inc;
  logic [CNT_W-1:0]        cnt_q [NUM_DROP_CNT];
  logic                    drop_now;

  assign drop_now   = end_fire && !end_accept;
  assign cnt_inc[0] = drop_now && (end_cause == DROP_ADDR);
  assign cnt_inc[1] = drop_now && (end_cause == DROP_MCAST);
  assign cnt_inc[2] = drop_now && (end_cause == DROP_LONG);
  assign cnt_inc[3] = drop_now && (end_cause == DROP_CRC);

  for (genvar g = 0; g < NUM_DROP_CNT; g++) begin : g_cnt
    rx_da_satcnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .inc(cnt_inc[g]), .q(cnt_q[g])
    );
  end

  assign cnt_addr  = cnt_q[0];
  assign cnt_mcast = cnt_q[1];
  assign cnt_long  = cnt_q[2];
  assign cnt_crc   = cnt_q[3];

  assign pop   = !busy && !list_empty;
  assign rd_en = busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      rem       <= '0;
      cur_len   <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_len   <= '0;
    end else begin
      if (pop) begin
        busy    <= 1'b1;
        rem     <= list_head;
        cur_len <= list_head;
      end else if (busy) begin
        rem <= rem - 1'b1;
        if (rem == LEN_W'(1)) busy <= 1'b0;
      end
      out_valid <= rd_en;
      out_last  <= rd_en && (rem == LEN_W'(1));
      if (rd_en && rem == LEN_W'(1)) out_len <= cur_len;
    end
  end

  logic [LEN_W-1:0] beats_seen;
  always_ff @(posedge clk) begin
    if (rst)                beats_seen <= '0;
    else if (out_last)      beats_seen <= '0;
    else if (out_valid)     beats_seen <= beats_seen + 1'b1;
  end

  // R10
  last_len_match_chk: assert property (@(posedge clk) disable iff (rst)
    out_last |-> (out_valid && out_len == beats_seen + 1'b1));

  // R11
  counter_with_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (cnt_crc != $past(cnt_crc)) |-> frame_drop);

endmodule

// File: tb/rx_da_filter_tb.sv
module rx_da_filter_tb;

  localparam int BUF_AW = 8;
  localparam int CNT_W  = 4;
  localparam int LEN_W  = BUF_AW + 1;
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 0, in_sof = 0, in_eof = 0, in_crc_err = 0;
  logic [7:0] in_data = 0;
  logic [31:0] cfg_addr_lo = 0;
  logic [15:0] cfg_addr_hi = 0;
  logic cfg_drop_addr = 0, cfg_drop_mcast = 0, cfg_strip_fcs = 0;
  logic [LEN_W-1:0] cfg_max_len = 0;
  logic out_valid, out_last, frame_accept, frame_drop;
  logic [7:0] out_data;
  logic [LEN_W-1:0] out_len;
  logic [CNT_W-1:0] cnt_addr, cnt_mcast, cnt_long, cnt_crc;

  always #10 clk = ~clk;

  rx_da_filter #(.BUF_AW(BUF_AW), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
    .in_crc_err(in_crc_err),
    .cfg_addr_lo(cfg_addr_lo), .cfg_addr_hi(cfg_addr_hi),
    .cfg_drop_addr(cfg_drop_addr), .cfg_drop_mcast(cfg_drop_mcast),
    .cfg_strip_fcs(cfg_strip_fcs), .cfg_max_len(cfg_max_len),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last), .out_len(out_len),
    .frame_accept(frame_accept), .frame_drop(frame_drop),
    .cnt_addr(cnt_addr), .cnt_mcast(cnt_mcast), .cnt_long(cnt_long), .cnt_crc(cnt_crc)
  );

  int n_checks = 0, n_fail = 0;
  int seed = 5;
  logic [7:0] da_tab [4][6];
  logic [7:0] st [6];
  logic [7:0] tx_buf [512];
  logic [7:0] rx_buf [512];
  int rx_cnt = 0, last_seen = 0, last_len = 0, acc_seen = 0, drp_seen = 0;
  int exp_cnt [4];
  bit dec_acc, dec_drp;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (out_valid) begin
      if (rx_cnt < 512) rx_buf[rx_cnt] = out_data;
      rx_cnt++;
      if (out_last) begin
        last_seen++;
        last_len = int'(out_len);
      end
    end
    if (frame_accept) acc_seen++;
    if (frame_drop) drp_seen++;
  end

  task automatic set_station();
    cfg_addr_lo = {st[3], st[2], st[1], st[0]};
    cfg_addr_hi = {st[5], st[4]};
  endtask

  task automatic clear_mon();
    rx_cnt = 0; last_seen = 0; last_len = 0; acc_seen = 0; drp_seen = 0;
  endtask

  task automatic send(input int kind, input int len, input bit crc, input bit finish);
    for (int i = 0; i < len; i++) begin
      logic [7:0] b;
      b = (i < 6) ? da_tab[kind][i] : 8'((i * 13 + seed) & 255);
      tx_buf[i] = b;
      in_valid = 1'b1;
      in_sof = (i == 0);
      in_eof = finish && (i == len - 1);
      in_crc_err = crc && finish && (i == len - 1);
      in_data = b;
      @(negedge clk);
    end
    in_valid = 0; in_sof = 0; in_eof = 0; in_crc_err = 0;
    dec_acc = frame_accept;
    dec_drp = frame_drop;
    seed = seed + 3;
  endtask

  // bench cause codes: 0 accept, 1 crc, 2 runt, 3 long, 4 mcast, 5 addr
  function automatic int model(input int kind, input int len, input bit crc);
    bit hit;
    if (crc) return 1;
    if (len < 60) return 2;
    if (len > int'(cfg_max_len)) return 3;
    if (cfg_drop_mcast && da_tab[kind][0][0]) return 4;
    hit = 1;
    for (int i = 0; i < 6; i++) if (da_tab[kind][i] != st[i]) hit = 0;
    if (cfg_drop_addr && !hit) return 5;
    return 0;
  endfunction

  task automatic run_case(input int kind, input int len, input bit crc, input string req);
    int cause, elen, bad;
    cause = model(kind, len, crc);
    clear_mon();
    send(kind, len, crc, 1'b1);
    chk(dec_acc == (cause == 0) && dec_drp == (cause != 0),
        $sformatf("R11 %s decision pulse", req), int'(dec_acc), int'(cause == 0));
    repeat (len + 12) @(negedge clk);
    chk(acc_seen + drp_seen == 1, "R11 one pulse per frame", acc_seen + drp_seen, 1);
    if (cause == 5) exp_cnt[0]++;
    if (cause == 4) exp_cnt[1]++;
    if (cause == 3) exp_cnt[2]++;
    if (cause == 1) exp_cnt[3]++;
    for (int i = 0; i < 4; i++) if (exp_cnt[i] > CMAX) exp_cnt[i] = CMAX;
    chk(int'(cnt_addr) == exp_cnt[0] && int'(cnt_mcast) == exp_cnt[1] &&
        int'(cnt_long) == exp_cnt[2] && int'(cnt_crc) == exp_cnt[3],
        $sformatf("R12 %s counters", req),
        int'({cnt_addr, cnt_mcast, cnt_long, cnt_crc}),
        (exp_cnt[0] << 12) | (exp_cnt[1] << 8) | (exp_cnt[2] << 4) | exp_cnt[3]);
    if (cause == 0) begin
      elen = cfg_strip_fcs ? len - 4 : len;
      chk(rx_cnt == elen && last_seen == 1 && last_len == elen,
          $sformatf("R10 R9 %s delivered length", req), last_len, elen);
      bad = 0;
      for (int i = 0; i < elen && i < 512; i++) if (rx_buf[i] != tx_buf[i]) bad++;
      chk(bad == 0, $sformatf("R10 %s byte order", req), bad, 0);
    end else begin
      chk(rx_cnt == 0 && last_seen == 0, $sformatf("R10 %s dropped frame silent", req),
          rx_cnt, 0);
    end
  endtask

  initial begin
    da_tab[0] = '{8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    da_tab[1] = '{8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h56};
    da_tab[2] = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    da_tab[3] = '{8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h01};
    st = '{8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    for (int i = 0; i < 4; i++) exp_cnt[i] = 0;
    set_station();
    cfg_max_len = LEN_W'(200);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid && !out_last && out_len == 0 && !frame_accept && !frame_drop,
        "R1 reset outputs", int'(out_valid), 0);
    chk(cnt_addr == 0 && cnt_mcast == 0 && cnt_long == 0 && cnt_crc == 0,
        "R1 reset counters", int'(cnt_crc), 0);

    // R2 R3 R4: enable grid x address kind x strip
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 4; k++) begin
        for (int s = 0; s < 2; s++) begin
          cfg_drop_addr = m[0];
          cfg_drop_mcast = m[1];
          cfg_strip_fcs = s[0];
          run_case(k, 64 + k, 1'b0, $sformatf("R2 R3 R4 m%0d k%0d s%0d", m, k, s));
        end
      end
    end

    // R5 broadcast with all-ones station
    st = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    set_station();
    cfg_drop_addr = 1; cfg_drop_mcast = 0;
    run_case(2, 70, 1'b0, "R5 broadcast to all-ones station");
    run_case(0, 70, 1'b0, "R5 unicast to all-ones station");
    st = '{8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
    set_station();

    // R7 runt boundary
    cfg_drop_addr = 0; cfg_drop_mcast = 0; cfg_strip_fcs = 1;
    for (int l = 56; l <= 63; l++) run_case(0, l, 1'b0, $sformatf("R7 len%0d", l));

    // R6 maximum length boundary
    cfg_max_len = LEN_W'(80);
    for (int l = 77; l <= 83; l++) begin
      cfg_strip_fcs = l[0];
      run_case(1, l, 1'b0, $sformatf("R6 len%0d", l));
    end
    cfg_max_len = LEN_W'(200);

    // R8 CRC priority
    cfg_drop_addr = 1; cfg_drop_mcast = 1;
    run_case(1, 64, 1'b1, "R8 crc with mismatch");
    run_case(3, 64, 1'b1, "R8 crc with multicast");
    run_case(0, 30, 1'b1, "R8 crc with runt");
    cfg_max_len = LEN_W'(70);
    run_case(0, 90, 1'b1, "R8 crc with oversize");
    cfg_max_len = LEN_W'(200);

    // R13 abandoned frame
    clear_mon();
    send(1, 30, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    chk(acc_seen + drp_seen == 0 && rx_cnt == 0, "R13 abandoned no decision",
        acc_seen + drp_seen, 0);
    cfg_strip_fcs = 0;
    run_case(0, 66, 1'b0, "R13 frame after abandon");

    // R12 saturation with 1-byte crc frames
    for (int n = 0; n < 20; n++) run_case(0, 1, 1'b1, $sformatf("R12 R8 sat %0d", n));
    chk(int'(cnt_crc) == CMAX, "R12 crc counter saturated", int'(cnt_crc), CMAX);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule